// File: doc/BRIEF.md
# Byte-Serial Multi-Precision Adder/Subtractor

This unit adds or subtracts two's-complement operands of one to four bytes. It has a single byte-wide adder with carry-in. The caller starts an operation by pulsing `start` while the unit is idle. With that pulse it gives the operation, the carry convention, a caller carry bit and the byte count. It then presents one byte of each operand per strobe, least-significant byte first. Each strobe yields one result byte on the following cycle. The carry out of each byte is held in a register and feeds the carry-in of the next byte.

Subtraction uses the same adder as addition. The B byte passes through an inverter row, and the first byte receives a carry-in of one. Two conventions decide where that first carry comes from. In forced mode the unit supplies it internally. In caller mode the unit takes it from the `carryIn` bit sampled with `start`. Once the last byte is processed, the unit reports three flags: the final carry, signed overflow, and whether every result byte was zero. It raises `done` for one cycle one cycle later.

Top module: `mpAddSub`

## Requirements
- R1: Each result byte is A + B + c when `opSub`=0 and A + (NOT B) + c when `opSub`=1, where c is the carry into that byte. For an addition the carry into the first byte is 0 in both carry modes.
- R2: With `carryMode`=1 (forced), the carry into the first byte of a subtraction is 1, whatever the value of `carryIn`.
- R3: With `carryMode`=0 (caller), the carry into the first byte of a subtraction equals `carryIn` as sampled in the `start` cycle. Changes to `carryIn` after that cycle have no effect.
- R4: Bytes are taken least-significant first. The carry out of each byte is the carry into the next byte. Each accepted strobe gives `resValid`=1 with its `resByte` on the next cycle only.
- R5: `carryOut` equals the carry out of the top bit of the last byte. All three flags read 0 from the cycle after an accepted `start` until the last result byte, and they keep their values after it.
- R6: `overflow` is the XOR of the carry into and the carry out of the top bit of the last byte only. For example, 64+65 gives 0x81 with overflow 1, and -64-65 gives 0x7F with carry 1 and overflow 1.
- R7: `zero` is 1 after the last byte only when every result byte of the operation was zero.
- R8: `start` has no effect while `busy`=1. `byteStrobe` has no effect outside an operation.
- R9: `done` is high for exactly one cycle, one cycle after the last `resValid`. `busy` is high from the cycle after an accepted `start` through the `done` cycle.
- R10: `byteCount` (1 to 4) sets how many bytes the operation takes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| opSub | input | 1 | 1 = subtract, 0 = add (sampled with start) |
| carryMode | input | 1 | 1 = forced first carry, 0 = caller carry (sampled with start) |
| carryIn | input | 1 | Caller first carry for subtraction (sampled with start) |
| byteCount | input | 3 | Number of bytes, 1 to 4 (sampled with start) |
| byteStrobe | input | 1 | Operand bytes present on aByte/bByte |
| aByte | input | 8 | Current byte of operand A |
| bByte | input | 8 | Current byte of operand B |
| resByte | output | 8 | Result byte |
| resValid | output | 1 | resByte valid this cycle |
| carryOut | output | 1 | Final carry flag |
| overflow | output | 1 | Signed overflow flag |
| zero | output | 1 | All-bytes-zero flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Each result byte and its valid strobe arrive one cycle after the edge that samples the byte strobe. The three flags change on that same edge for the last byte, `done` follows one cycle later, and `busy` drops one cycle after that. Every task drives inputs on the falling edge and reads outputs on the next falling edge, so each output is checked in exactly the cycle it becomes due. Some tasks insert idle cycles between strobes to show that nothing moves without a strobe. The expected bytes and flags come from a whole-word reference sum computed in the bench for the chosen byte count.

// File: rtl/mpAddSubPkg.sv
package mpAddSubPkg;
  typedef struct packed {
    logic load;   // operation accepted this cycle
    logic step;   // one byte processed this cycle
    logic last;   // the byte processed is the final one
  } ctrlStrobeT;
endpackage

// File: rtl/mpAddSubCtrl.sv
module mpAddSubCtrl
  import mpAddSubPkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             byteStrobe,
  input  logic [CNT_W-1:0] byteCount,
  output ctrlStrobeT       strobes,
  output logic             busy,
  output logic             done
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN, S_FIN} stateT;
  stateT state;
  logic [CNT_W-1:0] remain;

  always_comb begin
    strobes.load = (state == S_IDLE) && start;
    strobes.step = (state == S_RUN) && byteStrobe;
    strobes.last = strobes.step && (remain <= CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      remain <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          state  <= S_RUN;
          remain <= byteCount;
        end
        S_RUN: if (byteStrobe) begin
          remain <= remain - CNT_W'(1);
          if (strobes.last) state <= S_DRAIN;
        end
        S_DRAIN: state <= S_FIN;
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_FIN);
endmodule

// File: rtl/mpAddSubDpath.sv
module mpAddSubDpath
  import mpAddSubPkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobes,
  input  logic              opSub,
  input  logic              carryMode,
  input  logic              carryIn,
  input  logic [BYTE_W-1:0] aByte,
  input  logic [BYTE_W-1:0] bByte,
  output logic [BYTE_W-1:0] resByte,
  output logic              resValid,
  output logic              carryOut,
  output logic              overflow,
  output logic              zero
);
  localparam int LOW_W = BYTE_W - 1;

  logic              subQ;
  logic              carryQ;
  logic              zeroAcc;
  logic [BYTE_W-1:0] bEff;
  logic [BYTE_W-1:0] lowSum;
  logic [1:0]        msbSum;
  logic [BYTE_W-1:0] sum;
  logic              cIntoMsb;
  logic              cOutMsb;
  logic              sumIsZero;

  // Inverter row on the B path turns the adder into a subtractor.
  assign bEff = subQ ? ~bByte : bByte;

  // Split at the top bit so the carry into it is visible.
  assign lowSum   = {1'b0, aByte[LOW_W-1:0]} + {1'b0, bEff[LOW_W-1:0]}
                  + {{LOW_W{1'b0}}, carryQ};
  assign cIntoMsb = lowSum[LOW_W];
  assign msbSum   = {1'b0, aByte[BYTE_W-1]} + {1'b0, bEff[BYTE_W-1]}
                  + {1'b0, cIntoMsb};
  assign cOutMsb  = msbSum[1];
  assign sum      = {msbSum[0], lowSum[LOW_W-1:0]};
  assign sumIsZero = (sum == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      subQ     <= 1'b0;
      carryQ   <= 1'b0;
      zeroAcc  <= 1'b0;
      resByte  <= '0;
      resValid <= 1'b0;
      carryOut <= 1'b0;
      overflow <= 1'b0;
      zero     <= 1'b0;
    end else begin
      resValid <= strobes.step;
      if (strobes.load) begin
        subQ     <= opSub;
        carryQ   <= opSub & (carryMode | carryIn);
        zeroAcc  <= 1'b1;
        carryOut <= 1'b0;
        overflow <= 1'b0;
        zero     <= 1'b0;
      end else if (strobes.step) begin
        resByte <= sum;
        carryQ  <= cOutMsb;
        zeroAcc <= zeroAcc & sumIsZero;
        if (strobes.last) begin
          carryOut <= cOutMsb;
          overflow <= cIntoMsb ^ cOutMsb;
          zero     <= zeroAcc & sumIsZero;
        end
      end
    end
  end
endmodule

// File: rtl/mpAddSub.sv
module mpAddSub
  import mpAddSubPkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int MAX_BYTES = 4,
  localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              opSub,
  input  logic              carryMode,
  input  logic              carryIn,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic              byteStrobe,
  input  logic [BYTE_W-1:0] aByte,
  input  logic [BYTE_W-1:0] bByte,
  output logic [BYTE_W-1:0] resByte,
  output logic              resValid,
  output logic              carryOut,
  output logic              overflow,
  output logic              zero,
  output logic              busy,
  output logic              done
);
  ctrlStrobeT strobes;

  mpAddSubCtrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .byteStrobe(byteStrobe),
    .byteCount(byteCount), .strobes(strobes), .busy(busy), .done(done)
  );

  mpAddSubDpath #(.BYTE_W(BYTE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .opSub(opSub),
    .carryMode(carryMode), .carryIn(carryIn), .aByte(aByte), .bByte(bByte),
    .resByte(resByte), .resValid(resValid), .carryOut(carryOut),
    .overflow(overflow), .zero(zero)
  );
endmodule

// File: rtl/mpAddSubChk.sv
module mpAddSubChk (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic resValid,
  input logic carryOut,
  input logic overflow,
  input logic zero,
  input logic busy,
  input logic done
);
  // R9
  done_after_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(resValid));
  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R9
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(done));
  // R4
  valid_in_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> busy);
  // R6
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(overflow) |-> (resValid || $past(start && !busy)));
  // R5
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(carryOut) |-> (resValid || $past(start && !busy)));
  // R7
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(zero) |-> (resValid || $past(start && !busy)));
endmodule

bind mpAddSub mpAddSubChk u_chk (
  .clk(clk), .rstN(rstN), .start(start), .resValid(resValid),
  .carryOut(carryOut), .overflow(overflow), .zero(zero),
  .busy(busy), .done(done)
);

// File: tb/mpAddSub_tb.sv
module mpAddSub_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, opSub = 1'b0, carryMode = 1'b0, carryIn = 1'b0;
  logic [2:0] byteCount = 3'd1;
  logic byteStrobe = 1'b0;
  logic [7:0] aByte = '0, bByte = '0;
  logic [7:0] resByte;
  logic resValid, carryOut, overflow, zero, busy, done;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mpAddSub u_dut (
    .clk(clk), .rstN(rstN), .start(start), .opSub(opSub),
    .carryMode(carryMode), .carryIn(carryIn), .byteCount(byteCount),
    .byteStrobe(byteStrobe), .aByte(aByte), .bByte(bByte),
    .resByte(resByte), .resValid(resValid), .carryOut(carryOut),
    .overflow(overflow), .zero(zero), .busy(busy), .done(done)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One full operation; expected values from a whole-word reference sum.
  task automatic runOp(input logic sub, input logic mode, input logic cin,
                       input int n, input logic [31:0] a, input logic [31:0] b,
                       input bit gaps, input bit poke);
    logic [31:0] m, bE, res;
    logic [32:0] full;
    logic c0, expC, expV, sa, sb, sr;
    m    = (n == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * n)) - 32'h1);
    bE   = (sub ? ~b : b) & m;
    c0   = sub ? (mode ? 1'b1 : cin) : 1'b0;
    full = {1'b0, a & m} + {1'b0, bE} + {32'h0, c0};
    res  = full[31:0] & m;
    expC = full[8 * n];
    sa = a[8 * n - 1]; sb = bE[8 * n - 1]; sr = full[8 * n - 1];
    expV = (sa == sb) && (sr != sa);

    @(negedge clk);
    start = 1'b1; opSub = sub; carryMode = mode; carryIn = cin;
    byteCount = 3'(n);
    @(negedge clk);
    start = 1'b0; carryIn = ~cin;          // R3: later carryIn ignored
    chk("R9 busy after start", busy, 1);
    chk("R5 flags cleared", {carryOut, overflow, zero}, 0);
    for (int i = 0; i < n; i++) begin
      if (gaps) begin
        @(negedge clk);
        chk("R4 no result without strobe", resValid, 0);
      end
      byteStrobe = 1'b1; aByte = a[8 * i +: 8]; bByte = b[8 * i +: 8];
      if (poke) begin                        // R8: start while busy
        start = 1'b1; opSub = ~sub; byteCount = 3'd1;
      end
      @(negedge clk);
      byteStrobe = 1'b0; start = 1'b0;
      chk("R4 resValid", resValid, 1);
      chk("R1 R4 result byte", resByte, res[8 * i +: 8]);
      if (i < n - 1) begin
        chk("R6 R5 flags held before last", {carryOut, overflow, zero}, 0);
        chk("R9 no early done", done, 0);
      end
    end
    chk("R5 carryOut", carryOut, expC);
    chk("R6 overflow", overflow, expV);
    chk("R7 zero", zero, (res == 0));
    @(negedge clk);
    chk("R9 done pulse", done, 1);
    chk("R4 valid single", resValid, 0);
    @(negedge clk);
    chk("R9 done ends", done, 0);
    chk("R9 idle again", busy, 0);
    chk("R5 flags kept", {carryOut, overflow, zero}, {expC, expV, (res == 0)});
  endtask

  task automatic testReset;
    chk("R9 reset busy", busy, 0);
    chk("R9 reset done", done, 0);
    chk("R4 reset valid", resValid, 0);
    chk("R5 reset flags", {carryOut, overflow, zero}, 0);
  endtask

  task automatic testIdleStrobe;
    @(negedge clk);
    byteStrobe = 1'b1; aByte = 8'h12; bByte = 8'h34;
    @(negedge clk);
    byteStrobe = 1'b0;
    chk("R8 idle strobe ignored valid", resValid, 0);
    chk("R8 idle strobe ignored busy", busy, 0);
  endtask

  task automatic testDirected;
    runOp(0, 1, 0, 1, 32'd64, 32'd65, 0, 0);             // R6 0x81 ovf
    chk("R6 64+65 byte", resByte, 8'h81);
    runOp(1, 1, 0, 1, 32'hC0, 32'd65, 0, 0);             // R6 -64-65
    chk("R6 -64-65 byte", resByte, 8'h7F);
    runOp(1, 1, 0, 2, 32'd2000, 32'd1000, 0, 0);         // R2 forced
    runOp(1, 0, 1, 2, 32'd2000, 32'd1000, 0, 0);         // R3 caller 1
    runOp(1, 0, 0, 2, 32'd2000, 32'd1000, 0, 0);         // R3 caller 0
    chk("R3 borrow result high", resByte, 8'h03);
    runOp(0, 0, 1, 2, 32'd1000, 32'd5, 0, 0);            // R1 add ignores carryIn
    runOp(0, 1, 1, 3, 32'h00FF_FFFF, 32'h1, 0, 0);       // R4 carry ripple
    runOp(1, 1, 0, 2, 32'd1000, 32'd1000, 0, 0);         // R7 zero set
    runOp(0, 1, 0, 2, 32'h0100, 32'h0000, 0, 0);         // R7 low zero only
    runOp(0, 1, 0, 4, 32'h0000_0001, 32'h0, 0, 0);       // R7 high zero only
    runOp(1, 1, 0, 4, 32'h8000_0000, 32'h1, 1, 0);       // R10 four bytes, gaps
    runOp(0, 1, 0, 3, 32'h12_3456, 32'h65_4321, 0, 1);   // R8 start while busy
  endtask

  task automatic testRandom;
    for (int k = 0; k < 80; k++) begin
      runOp(1'($urandom), 1'(k & 1), 1'($urandom), (k % 4) + 1,
            $urandom, $urandom, 1'($urandom_range(0, 3) == 0), 0);  // R10
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testIdleStrobe();
    testDirected();
    testRandom();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule